// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Time-Base Trimming

This block keeps the time of day in three packed BCD registers (seconds, minutes and 24-hour hours). A single-cycle pulse `tb_pulse` arrives from a 32 Hz time base. A prescaler counts these pulses, and every `TB_DIV` counted pulses advance the seconds register by one. The seconds register carries into minutes, and minutes carry into hours. Software loads or reads any of the three time fields and a control register through a simple write port and a combinational read port. The control register holds a halt bit that stops the time base, a sign bit, and a calibration magnitude.

Calibration trims the time base, and a small state machine carries it out. It has three states: CAL_IDLE (no adjustment pending), CAL_ADD (inserting extra pulses) and CAL_DROP (swallowing incoming pulses). At each calibration-period boundary, which is every `CAL_PERIOD`-th seconds advance, the machine loads the current magnitude. It then takes one of three transitions: CAL_IDLE when the magnitude is zero, CAL_ADD when the sign is 1, and CAL_DROP when the sign is 0. In CAL_ADD, every running cycle without an incoming pulse gets one synthetic pulse. In CAL_DROP, every incoming pulse is discarded. Each inserted or dropped pulse consumes one unit. When the last unit is consumed, the machine returns to CAL_IDLE. A boundary reload overrides whatever is still pending.

The control register uses bit 7 for halt, bit 6 for sign (1 = add) and bits `CAL_W-1:0` for the magnitude.

Top module: `rtc_timekeeper`

## Requirements
- R1: After reset, seconds, minutes and hours read 0x00 and the control register reads 0x00, so the clock runs with no calibration.
- R2: Seconds (address 0) count in BCD from 00 to 59 and advance once for every `TB_DIV` effective pulses. From 59 the register returns to 00 and carries into minutes. Bit 7 always reads 0.
- R3: Minutes (address 1) count in BCD from 00 to 59. From 59 the register returns to 00 and carries into hours. Bit 7 always reads 0.
- R4: Hours (address 2) count in 24-hour BCD, so 09 goes to 10, 19 goes to 20, and 23 goes to 00. Bits 7:6 always read 0.
- R5: While control bit 7 (halt) is 1, `tb_pulse` is ignored. No time field, prescaler or calibration state changes, and `sec_tick` stays low.
- R6: The control register (address 3) reads back halt in bit 7, sign in bit 6 and the magnitude in bits 4:0. Bit 5 reads 0.
- R7: On the `CAL_PERIOD`-th seconds advance of each period, the magnitude is latched. With sign 1, that many extra pulses are inserted, one in each running cycle without `tb_pulse`. With sign 0, that many incoming `tb_pulse`s are discarded.
- R8: A write to address 0, 1 or 2 loads the field directly and clears the prescaler. In a cycle with such a write, no seconds advance occurs.
- R9: A non-BCD value written to a time field is stored and read back unchanged.
- R10: `sec_tick` is high in exactly the cycles whose closing clock edge advances seconds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_pulse | input | 1 | One-cycle time-base pulse (32 Hz nominal) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 sec, 1 min, 2 hour, 3 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | 8 | Combinational read data |
| sec_tick | output | 1 | High in the cycle in which seconds advance |

## Verification
The bench builds the block with `TB_DIV` = 4 and `CAL_PERIOD` = 4 while keeping the 5-bit magnitude. With these values a seconds advance needs only four pulses, and a calibration boundary arrives every four seconds. Many full insert and drop sequences therefore complete within a short run, including magnitudes that exceed the pulses in a second. Hour and day rollovers are reached by preloading 23:59:59, 09:59:59 and 19:59:59 rather than by counting a whole day.

// File: rtl/rtc_tk_pkg.sv
package rtc_tk_pkg;

    localparam logic [1:0] ADDR_SEC  = 2'd0;
    localparam logic [1:0] ADDR_MIN  = 2'd1;
    localparam logic [1:0] ADDR_HOUR = 2'd2;
    localparam logic [1:0] ADDR_CTRL = 2'd3;

    typedef enum logic [1:0] {
        CAL_IDLE = 2'd0,
        CAL_ADD  = 2'd1,
        CAL_DROP = 2'd2
    } cal_state_e;

    // Packed BCD increment; result {wrap, next}. Only the low digit 9 carries.
    function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] last);
        logic [3:0] hi_n;
        logic [3:0] lo_n;
        if (v == last) begin
            return 9'h100;
        end
        if (v[3:0] == 4'd9) begin
            hi_n = v[7:4] + 4'd1;
            return {1'b0, hi_n, 4'd0};
        end
        lo_n = v[3:0] + 4'd1;
        return {1'b0, v[7:4], lo_n};
    endfunction

endpackage

// File: rtl/tk_bcd_field.sv
module tk_bcd_field
    import rtc_tk_pkg::*;
#(
    parameter int          W    = 7,
    parameter logic [7:0]  LAST = 8'h59
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] val
);

    logic [8:0] stepped;

    always_comb begin
        stepped = bcd_step(8'(val), LAST);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (ld) begin
            val <= ld_data;
        end else if (inc) begin
            val <= stepped[W-1:0];
        end
    end

endmodule

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
    parameter int TB_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic eff_pulse,
    input  logic clr,
    output logic sec_adv
);

    localparam int            PS_W    = (TB_DIV > 2) ? $clog2(TB_DIV) : 1;
    localparam logic [PS_W-1:0] PS_LAST = PS_W'(TB_DIV - 1);

    logic [PS_W-1:0] pre_q;

    always_comb begin
        sec_adv = eff_pulse && (pre_q == PS_LAST) && !clr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr) begin
            pre_q <= '0;
        end else if (eff_pulse) begin
            pre_q <= (pre_q == PS_LAST) ? '0 : pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/tk_pulse_cal.sv
module tk_pulse_cal
    import rtc_tk_pkg::*;
#(
    parameter int CAL_W      = 5,
    parameter int CAL_PERIOD = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tb_pulse,
    input  logic             halt,
    input  logic             cal_add,
    input  logic [CAL_W-1:0] cal_mag,
    input  logic             sec_adv,
    output logic             eff_pulse
);

    localparam int               PER_W    = (CAL_PERIOD > 2) ? $clog2(CAL_PERIOD) : 1;
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(CAL_PERIOD - 1);

    cal_state_e       state_q, state_d;
    logic [CAL_W-1:0] left_q, left_d;
    logic [PER_W-1:0] per_q, per_d;
    logic             take;

    // Output process: effective pulse and unit consumption per state
    always_comb begin
        take      = 1'b0;
        eff_pulse = tb_pulse && !halt;
        unique case (state_q)
            CAL_IDLE: begin
            end
            CAL_ADD: begin
                if (!halt && !tb_pulse) begin
                    eff_pulse = 1'b1;
                    take      = 1'b1;
                end
            end
            CAL_DROP: begin
                if (!halt && tb_pulse) begin
                    eff_pulse = 1'b0;
                    take      = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    // Next-state process: consumption, period count, boundary reload
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        per_d   = per_q;
        if (take) begin
            left_d = left_q - 1'b1;
            if (left_q == CAL_W'(1)) begin
                state_d = CAL_IDLE;
            end
        end
        if (sec_adv) begin
            if (per_q == PER_LAST) begin
                per_d  = '0;
                left_d = cal_mag;
                if (cal_mag == '0) begin
                    state_d = CAL_IDLE;
                end else if (cal_add) begin
                    state_d = CAL_ADD;
                end else begin
                    state_d = CAL_DROP;
                end
            end else begin
                per_d = per_q + 1'b1;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CAL_IDLE;
            left_q  <= '0;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
            per_q   <= per_d;
        end
    end

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_tk_pkg::*;
#(
    parameter int TB_DIV     = 32,
    parameter int CAL_PERIOD = 64,
    parameter int CAL_W      = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tb_pulse,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       sec_tick
);

    localparam int SEC_W  = 7;
    localparam int HOUR_W = 6;

    logic             halt_q;
    logic             sign_q;
    logic [CAL_W-1:0] mag_q;

    logic             eff_pulse;
    logic             sec_adv;
    logic             time_wr;
    logic             ld_sec, ld_min, ld_hour;
    logic             min_inc, hour_inc;
    logic [SEC_W-1:0] sec_v, min_v;
    logic [HOUR_W-1:0] hour_v;

    always_comb begin
        time_wr  = wr_en && (wr_addr != ADDR_CTRL);
        ld_sec   = wr_en && (wr_addr == ADDR_SEC);
        ld_min   = wr_en && (wr_addr == ADDR_MIN);
        ld_hour  = wr_en && (wr_addr == ADDR_HOUR);
        min_inc  = sec_adv && (sec_v == 7'h59);
        hour_inc = min_inc && (min_v == 7'h59);
        sec_tick = sec_adv;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            sign_q <= 1'b0;
            mag_q  <= '0;
        end else if (wr_en && (wr_addr == ADDR_CTRL)) begin
            halt_q <= wr_data[7];
            sign_q <= wr_data[6];
            mag_q  <= wr_data[CAL_W-1:0];
        end
    end

    tk_pulse_cal #(
        .CAL_W      (CAL_W),
        .CAL_PERIOD (CAL_PERIOD)
    ) cal_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tb_pulse  (tb_pulse),
        .halt      (halt_q),
        .cal_add   (sign_q),
        .cal_mag   (mag_q),
        .sec_adv   (sec_adv),
        .eff_pulse (eff_pulse)
    );

    tk_prescaler #(
        .TB_DIV (TB_DIV)
    ) pre_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .eff_pulse (eff_pulse),
        .clr       (time_wr),
        .sec_adv   (sec_adv)
    );

    tk_bcd_field #(.W(SEC_W), .LAST(8'h59)) sec_i (
        .clk (clk), .rst_n (rst_n), .inc (sec_adv), .ld (ld_sec),
        .ld_data (wr_data[SEC_W-1:0]), .val (sec_v)
    );

    tk_bcd_field #(.W(SEC_W), .LAST(8'h59)) min_i (
        .clk (clk), .rst_n (rst_n), .inc (min_inc), .ld (ld_min),
        .ld_data (wr_data[SEC_W-1:0]), .val (min_v)
    );

    tk_bcd_field #(.W(HOUR_W), .LAST(8'h23)) hour_i (
        .clk (clk), .rst_n (rst_n), .inc (hour_inc), .ld (ld_hour),
        .ld_data (wr_data[HOUR_W-1:0]), .val (hour_v)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_SEC:  rd_data = {1'b0, sec_v};
            ADDR_MIN:  rd_data = {1'b0, min_v};
            ADDR_HOUR: rd_data = {2'b00, hour_v};
            ADDR_CTRL: begin
                rd_data[7]         = halt_q;
                rd_data[6]         = sign_q;
                rd_data[CAL_W-1:0] = mag_q;
            end
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tk_rtc_chk.sv
module tk_rtc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       halt,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic [7:0] wr_data,
    input logic [6:0] sec,
    input logic [6:0] min,
    input logic [5:0] hr
);

    // R10
    tick_moves_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> sec != $past(sec));

    // R5
    halt_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !sec_tick);

    // R5
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !wr_en) |=> ($stable(sec) && $stable(min) && $stable(hr)));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && sec == 7'h59) |=> sec == 7'h00);

    // R4
    day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && sec == 7'h59 && min == 7'h59 && hr == 6'h23) |=> hr == 6'h00);

    // R8
    sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd0) |=> sec == $past(wr_data[6:0]));

    // R8
    write_blocks_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != 2'd3) |-> !sec_tick);

endmodule

bind rtc_timekeeper tk_rtc_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sec_tick (sec_tick),
    .halt     (halt_q),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .sec      (sec_v),
    .min      (min_v),
    .hr       (hour_v)
);

// File: tb/rtc_timekeeper_tb.sv
`timescale 1ns/1ps
module rtc_timekeeper_tb_top;

    localparam int DIV = 4;
    localparam int PER = 4;
    localparam int CW  = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tb_pulse;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic       sec_tick;

    int errors = 0;
    int checks = 0;

    // reference model state
    int m_s, m_m, m_h, m_pre, m_per, m_left, m_mag;
    bit m_add, m_halt, m_sign;
    bit m_raw_ok;
    logic [7:0] m_raw;

    always #2.5 clk = ~clk;

    rtc_timekeeper #(.TB_DIV(DIV), .CAL_PERIOD(PER), .CAL_W(CW)) dut_i (
        .clk (clk), .rst_n (rst_n), .tb_pulse (tb_pulse), .wr_en (wr_en),
        .wr_addr (wr_addr), .wr_data (wr_data), .rd_addr (rd_addr),
        .rd_data (rd_data), .sec_tick (sec_tick)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] exp_reg(input int a);
        logic [7:0] r;
        case (a)
            0: r = m_raw_ok ? m_raw : to_bcd(m_s);
            1: r = to_bcd(m_m);
            2: r = to_bcd(m_h);
            default: r = {m_halt, m_sign, 1'b0, 5'(m_mag)};
        endcase
        return r;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_regs(input string tag);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #0.1;
            check(tag, rd_data, exp_reg(a));
        end
    endtask

    task automatic model_reset();
        m_s = 0; m_m = 0; m_h = 0; m_pre = 0; m_per = 0; m_left = 0; m_mag = 0;
        m_add = 0; m_halt = 0; m_sign = 0; m_raw_ok = 0; m_raw = 8'h00;
    endtask

    // one clock cycle: drive, predict, compare
    task automatic cyc(input logic tb, input logic we, input logic [1:0] wa,
                       input logic [7:0] wd, input string tag);
        bit eff, take, adv, twr;
        @(negedge clk);
        tb_pulse = tb; wr_en = we; wr_addr = wa; wr_data = wd;
        #0.5;
        twr  = we && (wa != 2'd3);
        eff  = tb && !m_halt;
        take = 0;
        if (!m_halt && m_left > 0) begin
            if (m_add && !tb) begin eff = 1; take = 1; end
            if (!m_add && tb) begin eff = 0; take = 1; end
        end
        adv = eff && (m_pre == DIV - 1) && !twr;
        checks++;
        if (sec_tick !== adv) begin
            errors++;
            $display("FAIL R10 %s: sec_tick actual %b expected %b at %0t", tag, sec_tick, adv, $time);
        end
        if (twr) m_pre = 0;
        else if (eff) m_pre = (m_pre == DIV - 1) ? 0 : m_pre + 1;
        if (take) m_left--;
        if (adv) begin
            if (m_per == PER - 1) begin
                m_per = 0; m_left = m_mag; m_add = m_sign;
            end else begin
                m_per++;
            end
            m_s++;
            if (m_s == 60) begin
                m_s = 0; m_m++;
                if (m_m == 60) begin
                    m_m = 0; m_h++;
                    if (m_h == 24) m_h = 0;
                end
            end
        end
        if (we) begin
            case (wa)
                2'd0: begin
                    m_s = from_bcd({1'b0, wd[6:0]});
                    m_raw_ok = (wd[3:0] > 4'd9);
                    m_raw = {1'b0, wd[6:0]};
                end
                2'd1: m_m = from_bcd({1'b0, wd[6:0]});
                2'd2: m_h = from_bcd({2'b00, wd[5:0]});
                default: begin
                    m_halt = wd[7]; m_sign = wd[6]; m_mag = int'(wd[4:0]);
                end
            endcase
        end
        @(posedge clk);
        #0.5;
        check_regs(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 8'h00, tag);
    endtask

    task automatic pulses(input int n, input int gap, input string tag);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, 2'd0, 8'h00, tag);
            for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 2'd0, 8'h00, tag);
        end
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        cyc(1'b0, 1'b1, 2'd2, h, "R8 load hour");
        cyc(1'b0, 1'b1, 2'd1, m, "R8 load min");
        cyc(1'b0, 1'b1, 2'd0, s, "R8 load sec");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        rst_n = 1'b0; tb_pulse = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        model_reset();
        repeat (3) @(posedge clk);
        #0.5;
        check_regs("R1 reset state");
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R3 R4: day rollover and digit carries
        set_time(8'h23, 8'h59, 8'h59);
        pulses(DIV + 1, 1, "R2 R3 R4 day wrap");
        set_time(8'h09, 8'h59, 8'h59);
        pulses(DIV, 0, "R4 09 to 10");
        set_time(8'h19, 8'h59, 8'h59);
        pulses(DIV * 3, 2, "R4 19 to 20");

        // R8: prescaler clear on time write, write beats a same-cycle advance
        pulses(2, 0, "R8 partial prescale");
        cyc(1'b0, 1'b1, 2'd0, 8'h30, "R8 write clears prescaler");
        pulses(DIV - 1, 0, "R8 no early advance");
        cyc(1'b1, 1'b1, 2'd1, 8'h12, "R8 write blocks advance");
        pulses(DIV, 0, "R8 full prescale after write");

        // R6: control readback
        cyc(1'b0, 1'b1, 2'd3, 8'hFF, "R6 control readback");
        cyc(1'b0, 1'b1, 2'd3, 8'h00, "R6 control clear");

        // R5: halt
        cyc(1'b0, 1'b1, 2'd3, 8'h80, "R5 set halt");
        pulses(40, 0, "R5 halted pulses ignored");
        cyc(1'b0, 1'b1, 2'd3, 8'h00, "R5 release halt");
        pulses(DIV * 2, 1, "R5 running again");

        // R7: calibration add and drop
        cyc(1'b0, 1'b1, 2'd3, 8'h40 | 8'h1F, "R7 add max");
        pulses(DIV * PER * 3, 3, "R7 add insert");
        idle(60, "R7 add insert idle base");
        cyc(1'b0, 1'b1, 2'd3, 8'h06, "R7 drop");
        pulses(DIV * PER * 6, 1, "R7 drop suppress");
        cyc(1'b0, 1'b1, 2'd3, 8'h00, "R7 cal off");
        pulses(DIV * PER * 2, 0, "R7 no cal");

        // R9: invalid BCD kept as written
        cyc(1'b0, 1'b1, 2'd0, 8'h5A, "R9 invalid digit readback");
        idle(3, "R9 invalid digit held");
        cyc(1'b0, 1'b1, 2'd0, 8'h00, "R9 restore");

        // random mix
        for (int i = 0; i < 20000; i++) begin
            logic tb, we;
            logic [1:0] wa;
            logic [7:0] wd;
            tb = (($urandom % 3) == 0);
            we = (($urandom % 150) == 0);
            wa = 2'($urandom % 4);
            case (wa)
                2'd0, 2'd1: wd = to_bcd($urandom % 60);
                2'd2:       wd = to_bcd($urandom % 24);
                default:    wd = {(($urandom % 8) == 0) ? 1'b1 : 1'b0, 1'($urandom), 1'b0, 5'($urandom)};
            endcase
            cyc(tb, we, wa, wd, "R2 R3 R5 R7 random");
        end

        finish_run();
    end

endmodule